// File: doc/BRIEF.md
# Complementary PWM Pair with Deadtime Distortion Correction

This block drives one complementary pair of switch outputs, an upper (top) switch and a lower (bottom) switch, from an edge-aligned PWM. Every rising edge on either output is delayed by a programmed deadtime, so the two switches never conduct together. The deadtime itself distorts the average output voltage, and which way it distorts depends on the sign of the load current. To offset this, the block holds two duty values, an even one and an odd one, and for each PWM cycle it picks one of them.

A two-bit method input sets how that choice is made. The choice can be fixed to the even value. It can follow a software polarity bit that takes effect on a reload. It can also follow a current-sense pin, which is low for positive load current and high for negative load current. The pin is captured at the end of each deadtime interval, and the two latest captures can be read back as status bits. The even/odd values and the polarity bit are double-buffered. They take effect at the first cycle boundary after a reload request. The method input is used as it stands and affects the cycle already under way.

Top module: `pwmDeadtimeCorr`

## Requirements
- R1: While `rstN` is low, both outputs and both status bits are 0.
- R2: A counter runs from 0 to `period`-1 and then wraps. The top drive is high while the count is below the selected value, and the bottom drive is its complement. Each output rises `deadTime`+1 clocks after its drive rises and falls one clock after its drive falls. Per cycle, the top is high for value-`deadTime` clocks and the bottom for `period`-value-`deadTime` clocks, clamped at 0. A value of at least `period` holds the top high and the bottom low.
- R3: `pwmTop` and `pwmBot` are never 1 in the same clock.
- R4: With `method` code 0 (and the unused code 3), the even value always sets the duty, whatever the polarity bit.
- R5: With `method` code 1, an active polarity of 0 selects the even value and 1 selects the odd value.
- R6: `evenVal`, `oddVal` and `polarity` reach their active copies only at the first cycle wrap after a `reloadReq` pulse. Without a pulse, writes to them have no effect, and a pulse that arrives mid-pulse leaves that pulse's width unchanged.
- R7: A change on `method` takes effect in the current cycle, including the pulse in progress.
- R8: On the clock where an output rises (the end of its deadtime), `isense` is captured into that side's status bit: `dtSampleTop` for the top, `dtSampleBot` for the bottom.
- R9: With `method` code 2, at each cycle wrap the most recent deadtime capture (from either side) selects the duty for the next cycle: 0 selects the even value and 1 selects the odd value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evenVal | input | CNT_W | Buffered even duty value |
| oddVal | input | CNT_W | Buffered odd duty value |
| period | input | CNT_W | PWM modulus in clocks |
| deadTime | input | DT_W | Deadtime in clocks |
| method | input | 2 | Correction method: 0 none, 1 manual, 2 current sense |
| polarity | input | 1 | Buffered manual selection bit |
| reloadReq | input | 1 | Requests transfer of the buffered values at the next wrap |
| isense | input | 1 | Current-sense level, high for negative current |
| pwmTop | output | 1 | Top switch drive |
| pwmBot | output | 1 | Bottom switch drive |
| dtSampleTop | output | 1 | `isense` captured at the end of the top deadtime |
| dtSampleBot | output | 1 | `isense` captured at the end of the bottom deadtime |

## Verification
The assertions assume that `isense` and all configuration inputs are synchronous to `clk` and change only between edges. They also assume that `period` is at least 2 while the counter runs. The bench drives every input on the falling edge and holds `period` and `deadTime` constant across each measurement window. It changes `isense` only after the output edge whose capture it is testing has been observed. Pulse widths are measured from an observed rising edge of `pwmTop`, so that reload and method changes land inside a known pulse.

// File: rtl/pwmCorrPkg.sv
package pwmCorrPkg;

  typedef struct packed {
    logic wrap;  // last clock of a PWM cycle
    logic load;  // buffered values transfer on this clock
  } cycStrobe_t;

  typedef enum logic [1:0] {
    METH_NONE   = 2'b00,
    METH_MANUAL = 2'b01,
    METH_SENSE  = 2'b10,
    METH_RSVD   = 2'b11
  } corrMethod_t;

endpackage

// File: rtl/pwmCorrCtrl.sv
module pwmCorrCtrl
  import pwmCorrPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] period,
  input  logic             reloadReq,
  output logic [CNT_W-1:0] cnt,
  output cycStrobe_t       strobe
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] periodM1;
  logic             reloadPend;

  assign periodM1    = period - ONE;
  assign strobe.wrap = (cnt >= periodM1);
  assign strobe.load = strobe.wrap && (reloadPend || reloadReq);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt        <= '0;
      reloadPend <= 1'b0;
    end else begin
      cnt <= strobe.wrap ? '0 : cnt + ONE;
      if (strobe.wrap)
        reloadPend <= 1'b0;
      else if (reloadReq)
        reloadPend <= 1'b1;
    end
  end

  // R6: a pending reload never survives a cycle wrap
  a_r6_pend_clear : assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrap |=> !reloadPend);

  // R2: the count restarts from zero after a wrap
  a_r2_restart : assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrap |=> (cnt == '0));

endmodule

// File: rtl/pwmCorrDatapath.sv
module pwmCorrDatapath
  import pwmCorrPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DT_W  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cnt,
  input  cycStrobe_t       strobe,
  input  logic [CNT_W-1:0] evenVal,
  input  logic [CNT_W-1:0] oddVal,
  input  logic [DT_W-1:0]  deadTime,
  input  logic [1:0]       method,
  input  logic             polarity,
  input  logic             isense,
  output logic [1:0]       pwmOut,
  output logic [1:0]       dtSample
);

  localparam int SIDES = 2;  // index 0 top, 1 bottom

  logic [CNT_W-1:0] actEven, actOdd, duty;
  logic             actPol, senseSel, lastSample, selOdd;
  logic [SIDES-1:0] rawDrv, dtEnd;
  corrMethod_t      meth;

  assign meth = corrMethod_t'(method);

  always_comb begin
    case (meth)
      METH_MANUAL: selOdd = actPol;
      METH_SENSE:  selOdd = senseSel;
      default:     selOdd = 1'b0;
    endcase
  end

  assign duty      = selOdd ? actOdd : actEven;
  assign rawDrv[0] = (cnt < duty);
  assign rawDrv[1] = ~rawDrv[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actEven    <= '0;
      actOdd     <= '0;
      actPol     <= 1'b0;
      senseSel   <= 1'b0;
      lastSample <= 1'b0;
    end else begin
      if (strobe.load) begin
        actEven <= evenVal;
        actOdd  <= oddVal;
        actPol  <= polarity;
      end
      if (strobe.wrap)
        senseSel <= lastSample;
      if (|dtEnd)
        lastSample <= isense;
    end
  end

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic [DT_W-1:0] dCnt;

    assign dtEnd[s] = rawDrv[s] && (dCnt == '0) && !pwmOut[s];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pwmOut[s]   <= 1'b0;
        dtSample[s] <= 1'b0;
        dCnt        <= '0;
      end else if (!rawDrv[s]) begin
        pwmOut[s] <= 1'b0;
        dCnt      <= deadTime;
      end else if (dCnt != '0) begin
        dCnt <= dCnt - DT_W'(1);
      end else if (!pwmOut[s]) begin
        pwmOut[s]   <= 1'b1;
        dtSample[s] <= isense;
      end
    end

    // R2: an output is only ever high after its drive was high
    a_r2_drive_first : assert property (@(posedge clk) disable iff (!rstN)
      pwmOut[s] |-> $past(rawDrv[s]));

    // R8: a rising output carries the sense level of that edge
    a_r8_capture : assert property (@(posedge clk) disable iff (!rstN)
      $rose(pwmOut[s]) |-> (dtSample[s] == $past(isense)));
  end

  // R3: the pair never conducts together
  a_r3_never_both : assert property (@(posedge clk) disable iff (!rstN)
    !(pwmOut[0] && pwmOut[1]));

endmodule

// File: rtl/pwmDeadtimeCorr.sv
module pwmDeadtimeCorr
  import pwmCorrPkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DT_W  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] evenVal,
  input  logic [CNT_W-1:0] oddVal,
  input  logic [CNT_W-1:0] period,
  input  logic [DT_W-1:0]  deadTime,
  input  logic [1:0]       method,
  input  logic             polarity,
  input  logic             reloadReq,
  input  logic             isense,
  output logic             pwmTop,
  output logic             pwmBot,
  output logic             dtSampleTop,
  output logic             dtSampleBot
);

  logic [CNT_W-1:0] cnt;
  cycStrobe_t       strobe;
  logic [1:0]       pwmOut, dtSample;

  pwmCorrCtrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .period    (period),
    .reloadReq (reloadReq),
    .cnt       (cnt),
    .strobe    (strobe)
  );

  pwmCorrDatapath #(.CNT_W(CNT_W), .DT_W(DT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cnt      (cnt),
    .strobe   (strobe),
    .evenVal  (evenVal),
    .oddVal   (oddVal),
    .deadTime (deadTime),
    .method   (method),
    .polarity (polarity),
    .isense   (isense),
    .pwmOut   (pwmOut),
    .dtSample (dtSample)
  );

  assign pwmTop      = pwmOut[0];
  assign pwmBot      = pwmOut[1];
  assign dtSampleTop = dtSample[0];
  assign dtSampleBot = dtSample[1];

endmodule

// File: tb/pwmDeadtimeCorr_bench.sv
module pwmDeadtimeCorr_bench;

  localparam int PER = 64;
  localparam int DT  = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] evenVal = 8'd20, oddVal = 8'd40, period = 8'(PER);
  logic [5:0] deadTime = 6'(DT);
  logic [1:0] method = 2'd0;
  logic       polarity = 1'b0, reloadReq = 1'b0, isense = 1'b0;
  logic       pwmTop, pwmBot, dtSampleTop, dtSampleBot;

  int nChecks = 0, nFails = 0, bothSeen = 0;

  always #5 clk = ~clk;

  pwmDeadtimeCorr u_pwmDeadtimeCorr (
    .clk(clk), .rstN(rstN), .evenVal(evenVal), .oddVal(oddVal),
    .period(period), .deadTime(deadTime), .method(method),
    .polarity(polarity), .reloadReq(reloadReq), .isense(isense),
    .pwmTop(pwmTop), .pwmBot(pwmBot),
    .dtSampleTop(dtSampleTop), .dtSampleBot(dtSampleBot)
  );

  always @(negedge clk) if (rstN && pwmTop && pwmBot) bothSeen++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3 * PER) @(negedge clk);
  endtask

  task automatic doReload();
    reloadReq = 1'b1;
    @(negedge clk);
    reloadReq = 1'b0;
  endtask

  task automatic countWindow(output int topC, output int botC);
    topC = 0; botC = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (pwmTop) topC++;
      if (pwmBot) botC++;
    end
  endtask

  task automatic waitTopRise();
    do @(negedge clk); while (pwmTop);
    do @(negedge clk); while (!pwmTop);
  endtask

  // assumes pwmTop was just seen rising; clears reloadReq on the way
  task automatic measureRest(output int w);
    w = 1;
    forever begin
      @(negedge clk);
      reloadReq = 1'b0;
      if (!pwmTop) break;
      w++;
    end
  endtask

  task automatic testReset();
    repeat (4) @(negedge clk);
    check(pwmTop == 0 && pwmBot == 0, "R1 outputs", int'({pwmTop, pwmBot}), 0);
    check(dtSampleTop == 0 && dtSampleBot == 0, "R1 status",
          int'({dtSampleTop, dtSampleBot}), 0);
    rstN = 1'b1;
  endtask

  task automatic testNoCorrection();
    int t, b, w;
    method = 2'd0; polarity = 1'b1;
    doReload(); settle();
    countWindow(t, b);
    check(t == 20 - DT, "R4 top width even", t, 20 - DT);
    check(b == PER - 20 - DT, "R2 bottom width", b, PER - 20 - DT);
    method = 2'd3; settle();
    waitTopRise(); measureRest(w);
    check(w == 20 - DT, "R4 code 3 as none", w, 20 - DT);
    method = 2'd0;
  endtask

  task automatic testBoundaries();
    int t, b;
    evenVal = 8'd30; settle();
    countWindow(t, b);
    check(t == 20 - DT, "R6 no reload no change", t, 20 - DT);
    doReload(); settle();
    countWindow(t, b);
    check(t == 30 - DT, "R6 reload applies", t, 30 - DT);
    evenVal = 8'd2; doReload(); settle();
    countWindow(t, b);
    check(t == 0, "R2 value below deadtime top", t, 0);
    check(b == PER - 2 - DT, "R2 value below deadtime bottom", b, PER - 2 - DT);
    evenVal = 8'd80; doReload(); settle();
    countWindow(t, b);
    check(t == PER, "R2 value over period top", t, PER);
    check(b == 0, "R2 value over period bottom", b, 0);
    evenVal = 8'd20; doReload(); settle();
  endtask

  task automatic testManual();
    int w;
    method = 2'd1; polarity = 1'b1; doReload(); settle();
    waitTopRise(); measureRest(w);
    check(w == 40 - DT, "R5 polarity 1 odd", w, 40 - DT);
    waitTopRise();
    polarity = 1'b0; reloadReq = 1'b1;
    measureRest(w);
    check(w == 40 - DT, "R6 pulse in progress keeps odd", w, 40 - DT);
    waitTopRise(); measureRest(w);
    check(w == 20 - DT, "R5 polarity 0 even next cycle", w, 20 - DT);
    polarity = 1'b1;
    waitTopRise(); measureRest(w);
    check(w == 20 - DT, "R6 polarity without reload ignored", w, 20 - DT);
    doReload(); settle();
  endtask

  task automatic testMethodImmediate();
    int w;
    waitTopRise();
    method = 2'd0;
    measureRest(w);
    check(w == 20 - DT, "R7 switch to none mid pulse", w, 20 - DT);
    waitTopRise();
    method = 2'd1;
    measureRest(w);
    check(w == 40 - DT, "R7 switch to manual mid pulse", w, 40 - DT);
  endtask

  task automatic testSense();
    int w;
    method = 2'd2; isense = 1'b1; settle();
    waitTopRise(); measureRest(w);
    check(w == 40 - DT, "R9 negative current odd", w, 40 - DT);
    check(dtSampleTop == 1 && dtSampleBot == 1, "R8 both captured 1",
          int'({dtSampleTop, dtSampleBot}), 3);
    isense = 1'b0; settle();
    waitTopRise(); measureRest(w);
    check(w == 20 - DT, "R9 positive current even", w, 20 - DT);
    check(dtSampleTop == 0 && dtSampleBot == 0, "R8 both captured 0",
          int'({dtSampleTop, dtSampleBot}), 0);
    // top captures 1, bottom captures 0: latest is 0
    isense = 1'b1; settle();
    waitTopRise(); isense = 1'b0;
    do @(negedge clk); while (!pwmBot);
    check(dtSampleTop == 1 && dtSampleBot == 0, "R8 per side capture",
          int'({dtSampleTop, dtSampleBot}), 2);
    waitTopRise(); measureRest(w);
    check(w == 20 - DT, "R9 latest capture 0 wins", w, 20 - DT);
    // top captures 0, bottom captures 1: latest is 1
    isense = 1'b0; settle();
    waitTopRise(); isense = 1'b1;
    do @(negedge clk); while (!pwmBot);
    check(dtSampleTop == 0 && dtSampleBot == 1, "R8 per side capture swapped",
          int'({dtSampleTop, dtSampleBot}), 1);
    waitTopRise(); measureRest(w);
    check(w == 40 - DT, "R9 latest capture 1 wins", w, 40 - DT);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    testReset();
    testNoCorrection();
    testBoundaries();
    testManual();
    testMethodImmediate();
    testSense();
    check(bothSeen == 0, "R3 never both high", bothSeen, 0);
    summary();
    $finish;
  end

endmodule